// File: doc/BRIEF.md
# TFT Column Driver Line Front-End

This block is the digital half of a six-column driver for a thin-film-transistor panel. One pixel arrives per data clock as a 6-bit word holding three 2-bit color levels. A start pulse begins a scan that writes consecutive pixel words into a sampling line register. When a line is complete, a carry pulse is passed on to the next driver in the chain. A separate, slower control clock marks each line boundary. Its rising edge, brought into the data clock domain, copies the whole sampling register into an output register in one step.

The output register drives one level code per column. The block also gives each column a polarity bit for dot inversion and the target voltage in millivolts that the analog stage must produce. The scan order can be reversed for mirrored panel mounting. When it is, the two chain pins swap their input and output roles.

Top module: `lcd_col_front`

## Requirements
- R1: `pix_rgb` bits [1:0] carry red, [3:2] green and [5:4] blue. Pixel slot p feeds columns 3p (red), 3p+1 (green) and 3p+2 (blue), with column index 0-based.
- R2: When `rev_dir`=0, a high `chain_l_i` at a clock edge writes that cycle's word into slot 0, and the next edge writes into slot 1. Words presented while no scan is running are ignored.
- R3: A one-cycle carry pulse appears in the cycle after the last slot is written. It is on `chain_r_o` in forward order and on `chain_l_o` in reverse order, and the other carry output stays 0.
- R4: When `rev_dir`=1, a high `chain_r_i` starts the scan, and slots are filled from the last slot down to slot 0.
- R5: A high level on the start input of the unused side (`chain_r_i` in forward order, `chain_l_i` in reverse order) neither starts a scan nor writes any slot.
- R6: A start pulse that arrives during a scan restarts it: the first slot is overwritten and the scan continues from there.
- R7: The column outputs change only on a line transfer. If `ctl_clk` rises before clock edge k, the new line is visible after edge k+2, and the old line is still present after edge k+1.
- R8: `pol_sel` is captured only at a line transfer. Columns with even index take the captured value as their `ch_pos` bit, and columns with odd index take its inverse (1 = positive).
- R9: `ch_mv` for each column is 500 + 1500·code when its polarity is negative, and 7000 + 1500·code when it is positive (14 bits per column).
- R10: While `rst_n` is low, both line registers, the captured polarity and the scan state are cleared. Both carry outputs are then 0 and every code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_clk | input | 1 | Line control clock; its rising edge requests a transfer |
| pol_sel | input | 1 | Polarity of the even-index columns for the next line |
| rev_dir | input | 1 | 1 = reverse scan order |
| chain_l_i | input | 1 | Start input in forward order |
| chain_r_i | input | 1 | Start input in reverse order |
| pix_rgb | input | 6 | One pixel: three 2-bit levels |
| chain_l_o | output | 1 | Carry out in reverse order |
| chain_r_o | output | 1 | Carry out in forward order |
| ch_code | output | 12 | Level code per column, 2 bits each, column 0 in bits [1:0] |
| ch_pos | output | 6 | Polarity per column, 1 = positive |
| ch_mv | output | 84 | Target millivolts per column, 14 bits each |

## Verification
The rotating color ramp (red 0,1,2,3, green offset by one, blue offset by two) runs in both scan orders. Because each color holds a different code in each slot, a swapped slot, a swapped color field or a reversed fill order all produce visible mismatches. Directed lines cover a restart during a scan, a start on the unused side and a toggle of `pol_sel` between transfers. Together these separate correct restart, side selection and capture-at-transfer from free-running behavior. Random lines with random direction and polarity then cover every code paired with both polarities, which exercises the whole millivolt mapping.

// File: rtl/lcd_col_pkg.sv
package lcd_col_pkg;
  localparam int CODE_W    = 2;
  localparam int COLORS    = 3;
  localparam int PIX_W     = CODE_W * COLORS;
  localparam int MV_W      = 14;
  localparam int MV_NEG_LO = 500;
  localparam int MV_POS_LO = 7000;
  localparam int MV_STEP   = 1500;

  function automatic logic [MV_W-1:0] level_to_mv(input logic [CODE_W-1:0] code,
                                                  input logic pos);
    logic [MV_W-1:0] base;
    base = pos ? MV_W'(MV_POS_LO) : MV_W'(MV_NEG_LO);
    return base + MV_W'(code) * MV_W'(MV_STEP);
  endfunction
endpackage

// File: rtl/lcd_col_strobe.sv
module lcd_col_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_clk,
  output logic load
);
  logic [2:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[1:0], ctl_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign load = sync_q[1] & ~sync_q[2];

  // a strobe never lasts two cycles
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);
endmodule

// File: rtl/lcd_col_scan.sv
module lcd_col_scan #(
  parameter int NPIX = 2,
  localparam int SLOT_W = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rev_dir,
  input  logic              chain_l_i,
  input  logic              chain_r_i,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic              chain_l_o,
  output logic              chain_r_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NPIX - 1);

  logic              active_q, active_d;
  logic              dir_q, dir_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              carry_q, carry_d;
  logic              cdir_q, cdir_d;
  logic              start, at_end;

  assign start  = rev_dir ? chain_r_i : chain_l_i;
  assign at_end = dir_q ? (slot_q == '0) : (slot_q == LAST);

  always_comb begin
    active_d = active_q;
    dir_d    = dir_q;
    slot_d   = slot_q;
    carry_d  = 1'b0;
    cdir_d   = cdir_q;
    wr_en    = 1'b0;
    wr_slot  = slot_q;
    if (start) begin
      wr_en   = 1'b1;
      wr_slot = rev_dir ? LAST : '0;
      dir_d   = rev_dir;
      if (NPIX == 1) begin
        active_d = 1'b0;
        carry_d  = 1'b1;
        cdir_d   = rev_dir;
      end else begin
        active_d = 1'b1;
        slot_d   = rev_dir ? SLOT_W'(NPIX - 2) : SLOT_W'(1);
      end
    end else if (active_q) begin
      wr_en = 1'b1;
      if (at_end) begin
        active_d = 1'b0;
        carry_d  = 1'b1;
        cdir_d   = dir_q;
      end else begin
        slot_d = dir_q ? slot_q - SLOT_W'(1) : slot_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dir_q    <= 1'b0;
      slot_q   <= '0;
      carry_q  <= 1'b0;
      cdir_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      dir_q    <= dir_d;
      slot_q   <= slot_d;
      carry_q  <= carry_d;
      cdir_q   <= cdir_d;
    end
  end

  assign chain_r_o = carry_q & ~cdir_q;
  assign chain_l_o = carry_q & cdir_q;

  assert_slot_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_slot) < NPIX));
  assert_carry_one_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(chain_l_o && chain_r_o));
  generate
    if (NPIX > 1) begin : g_pulse_chk
      assert_carry_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_l_o || chain_r_o) |=> !(chain_l_o || chain_r_o));
    end
  endgenerate
endmodule

// File: rtl/lcd_col_latch.sv
module lcd_col_latch
  import lcd_col_pkg::*;
#(
  parameter int NPIX = 2,
  localparam int SLOT_W = (NPIX > 1) ? $clog2(NPIX) : 1,
  localparam int NCH = NPIX * COLORS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SLOT_W-1:0]     wr_slot,
  input  logic [PIX_W-1:0]      pix,
  input  logic                  load,
  input  logic                  pol_sel,
  output logic [NCH*CODE_W-1:0] code,
  output logic [NCH-1:0]        pos
);
  logic [NPIX*PIX_W-1:0] samp_q, samp_d;
  logic [NCH*CODE_W-1:0] hold_q, hold_d;
  logic                  pol_q, pol_d;

  generate
    for (genvar p = 0; p < NPIX; p++) begin : g_slot
      always_comb begin
        if (wr_en && (wr_slot == SLOT_W'(p))) samp_d[p*PIX_W +: PIX_W] = pix;
        else                                  samp_d[p*PIX_W +: PIX_W] = samp_q[p*PIX_W +: PIX_W];
      end
    end
  endgenerate

  always_comb begin
    hold_d = load ? samp_q : hold_q;
    pol_d  = load ? pol_sel : pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      hold_q <= '0;
      pol_q  <= 1'b0;
    end else begin
      samp_q <= samp_d;
      hold_q <= hold_d;
      pol_q  <= pol_d;
    end
  end

  assign code = hold_q;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_pol
      if (i % 2 == 0) begin : g_even
        assign pos[i] = pol_q;
      end else begin : g_odd
        assign pos[i] = ~pol_q;
      end
    end
  endgenerate

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(code));
  assert_pol_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(pos));
endmodule

// File: rtl/lcd_col_level.sv
module lcd_col_level
  import lcd_col_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*CODE_W-1:0] code,
  input  logic [NCH-1:0]        pos,
  output logic [NCH*MV_W-1:0]   mv
);
  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign mv[i*MV_W +: MV_W] = level_to_mv(code[i*CODE_W +: CODE_W], pos[i]);

      assert_mv_band_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pos[i] ? (int'(mv[i*MV_W +: MV_W]) >= MV_POS_LO)
               : (int'(mv[i*MV_W +: MV_W]) <= MV_NEG_LO + 3 * MV_STEP));
    end
  endgenerate
endmodule

// File: rtl/lcd_col_front.sv
module lcd_col_front
  import lcd_col_pkg::*;
#(
  parameter int NPIX = 2,
  localparam int NCH = NPIX * COLORS,
  localparam int SLOT_W = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_clk,
  input  logic                  pol_sel,
  input  logic                  rev_dir,
  input  logic                  chain_l_i,
  input  logic                  chain_r_i,
  input  logic [PIX_W-1:0]      pix_rgb,
  output logic                  chain_l_o,
  output logic                  chain_r_o,
  output logic [NCH*CODE_W-1:0] ch_code,
  output logic [NCH-1:0]        ch_pos,
  output logic [NCH*MV_W-1:0]   ch_mv
);
  logic              wr_en;
  logic [SLOT_W-1:0] wr_slot;
  logic              load;

  lcd_col_scan #(.NPIX(NPIX)) u_scan (
    .clk(clk), .rst_n(rst_n), .rev_dir(rev_dir),
    .chain_l_i(chain_l_i), .chain_r_i(chain_r_i),
    .wr_en(wr_en), .wr_slot(wr_slot),
    .chain_l_o(chain_l_o), .chain_r_o(chain_r_o)
  );

  lcd_col_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .ctl_clk(ctl_clk), .load(load)
  );

  lcd_col_latch #(.NPIX(NPIX)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
    .pix(pix_rgb), .load(load), .pol_sel(pol_sel),
    .code(ch_code), .pos(ch_pos)
  );

  lcd_col_level #(.NCH(NCH)) u_level (
    .clk(clk), .rst_n(rst_n), .code(ch_code), .pos(ch_pos), .mv(ch_mv)
  );
endmodule

// File: tb/sim_lcd_col_front.sv
module sim_lcd_col_front;
  localparam int NCH = 6;

  logic clk = 1'b0;
  logic rst_n, ctl_clk, pol_sel, rev_dir, chain_l_i, chain_r_i;
  logic [5:0]      pix_rgb;
  logic            chain_l_o, chain_r_o;
  logic [11:0]     ch_code;
  logic [5:0]      ch_pos;
  logic [83:0]     ch_mv;

  int nvec = 0;
  int nfail = 0;
  int e_samp[NCH];
  int e_hold[NCH];
  int e_pol = 0;

  always #2.5 clk = ~clk;

  lcd_col_front u0 (
    .clk(clk), .rst_n(rst_n), .ctl_clk(ctl_clk), .pol_sel(pol_sel),
    .rev_dir(rev_dir), .chain_l_i(chain_l_i), .chain_r_i(chain_r_i),
    .pix_rgb(pix_rgb), .chain_l_o(chain_l_o), .chain_r_o(chain_r_o),
    .ch_code(ch_code), .ch_pos(ch_pos), .ch_mv(ch_mv)
  );

  function automatic int exp_pos(int ch, int pol);
    return (ch % 2 == 0) ? pol : 1 - pol;
  endfunction

  function automatic int exp_mv(int code, int pos);
    return (pos != 0 ? 7000 : 500) + 1500 * code;
  endfunction

  function automatic logic [5:0] ramp(int k);
    return {2'((k + 2) % 4), 2'((k + 1) % 4), 2'(k % 4)};
  endfunction

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_slot(int slot, logic [5:0] p);
    for (int c = 0; c < 3; c++) e_samp[3*slot + c] = int'(p[2*c +: 2]);
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < NCH; i++) begin
      chk({req, " code"}, int'(ch_code[2*i +: 2]), e_hold[i]);
      chk({req, " R8 pos"}, int'(ch_pos[i]), exp_pos(i, e_pol));
      chk({req, " R9 mv"}, int'(ch_mv[14*i +: 14]), exp_mv(e_hold[i], exp_pos(i, e_pol)));
    end
  endtask

  // one full line scan; checks the carry pulse (R3)
  task automatic scan_line(bit rev, logic [5:0] p0, logic [5:0] p1);
    @(negedge clk);
    rev_dir = rev;
    if (rev) chain_r_i = 1'b1; else chain_l_i = 1'b1;
    pix_rgb = p0;
    @(negedge clk);
    chain_r_i = 1'b0; chain_l_i = 1'b0;
    pix_rgb = p1;
    chk("R3 no early carry", int'(chain_l_o | chain_r_o), 0);
    @(negedge clk);
    chk("R3 carry on out side", int'(rev ? chain_l_o : chain_r_o), 1);
    chk("R3 other side quiet", int'(rev ? chain_r_o : chain_l_o), 0);
    pix_rgb = 6'($urandom);
    @(negedge clk);
    chk("R3 carry one cycle", int'(chain_l_o | chain_r_o), 0);
    if (rev) begin put_slot(1, p0); put_slot(0, p1); end
    else     begin put_slot(0, p0); put_slot(1, p1); end
  endtask

  // line transfer; checks timing (R7) and capture of pol_sel (R8)
  task automatic do_load(bit pol);
    @(negedge clk);
    pol_sel = pol;
    ctl_clk = 1'b1;
    pix_rgb = 6'($urandom);
    @(negedge clk);
    @(negedge clk);
    check_all("R7 before transfer");
    @(negedge clk);
    e_hold = e_samp;
    e_pol  = int'(pol);
    check_all("R7 R1 after transfer");
    ctl_clk = 1'b0;
    pol_sel = ~pol;
    repeat (3) @(negedge clk);
    check_all("R8 pol_sel ignored between transfers");
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [5:0] a, b, c;
    void'($urandom(32'd4711));
    for (int i = 0; i < NCH; i++) begin e_samp[i] = 0; e_hold[i] = 0; end
    rst_n = 1'b0; ctl_clk = 1'b0; pol_sel = 1'b0; rev_dir = 1'b0;
    chain_l_i = 1'b0; chain_r_i = 1'b0; pix_rgb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R10 reset");
    chk("R10 carry low", int'(chain_l_o | chain_r_o), 0);

    // color ramp, forward then reverse (R1 R2 R4)
    scan_line(1'b0, ramp(0), ramp(1));
    do_load(1'b1);
    scan_line(1'b0, ramp(2), ramp(3));
    do_load(1'b0);
    scan_line(1'b1, ramp(0), ramp(1));
    do_load(1'b1);
    scan_line(1'b1, ramp(2), ramp(3));
    do_load(1'b0);

    // R2: idle words do not write
    @(negedge clk); pix_rgb = 6'h3f;
    repeat (3) @(negedge clk);
    do_load(1'b1);

    // R5: start on the unused side is ignored in both orders
    @(negedge clk); rev_dir = 1'b0; chain_r_i = 1'b1; pix_rgb = 6'h15;
    @(negedge clk); chain_r_i = 1'b0; pix_rgb = 6'h2a;
    @(negedge clk);
    chk("R5 no carry fwd", int'(chain_l_o | chain_r_o), 0);
    @(negedge clk); rev_dir = 1'b1; chain_l_i = 1'b1; pix_rgb = 6'h15;
    @(negedge clk); chain_l_i = 1'b0; pix_rgb = 6'h2a;
    @(negedge clk);
    chk("R5 no carry rev", int'(chain_l_o | chain_r_o), 0);
    do_load(1'b0);

    // R6: restart during a scan
    @(negedge clk); rev_dir = 1'b0; chain_l_i = 1'b1; pix_rgb = 6'h01;
    @(negedge clk); pix_rgb = 6'h1b;
    @(negedge clk); chain_l_i = 1'b0; pix_rgb = 6'h24;
    chk("R6 no carry after restart", int'(chain_r_o), 0);
    @(negedge clk);
    chk("R6 carry after restarted scan", int'(chain_r_o), 1);
    put_slot(0, 6'h1b); put_slot(1, 6'h24);
    do_load(1'b1);

    // random lines
    for (int n = 0; n < 24; n++) begin
      a = 6'($urandom); b = 6'($urandom); c = 6'($urandom);
      scan_line(bit'($urandom % 2), a, b);
      do_load(bit'($urandom % 2));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule